// File: doc/BRIEF.md
# Low-Segment Swap Address Decoder

This decoder sits on the slave side of a system bus. It sorts each address into 64 MB segments and raises one select for the backing region that owns the access: boot ROM, external SDRAM or the memory bank on chip select 0. Segment 0 is an alias, and a two-bit swap register picks its target at run time. After any reset the alias points at the boot ROM, so the reset vector at 0x0000_0000 fetches boot code. Later, software can point segment 0 at SDRAM or at the memory bank. The exception vectors (0x0000_0000 to 0x0000_001F) then sit in writable memory.

The home segments of the three regions decode the same way whatever the swap register holds. If the swap register holds the reserved code, segment 0 belongs to nobody. An access there then returns a one-cycle error strobe instead of a select. Results are registered: the select, the offset and the error appear in the cycle after the access is presented. The memories themselves are outside this block.

Top module: `lsr_decoder`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, all selects, the error strobe and the offset are 0. Every reset returns the swap code to 2'b00 (ROM).
- R2: With swap code 2'b00, a valid access whose address bits [31:26] are 0 raises `sel_rom` in the next cycle, with `out_offset` equal to address bits [25:0]. This includes every vector address 0x00 to 0x1F.
- R3: With swap code 2'b01, a valid segment-0 access raises `sel_sdram` in the next cycle, with the offset passed through.
- R4: With swap code 2'b10, a valid segment-0 access raises `sel_bank` in the next cycle, with the offset passed through.
- R5: With swap code 2'b11, a valid segment-0 access raises `bus_err` for exactly one cycle per access. No select is raised and the offset is 0.
- R6: Segment 4 always selects the ROM, segment 2 always selects SDRAM and segment 3 always selects the memory bank, under every swap code. The offset is passed through.
- R7: A swap write is visible from the next access on. An access presented in the same cycle as the write still uses the previous code.
- R8: A cycle without `bus_valid` gives no select, no error and a zero offset in the following cycle.
- R9: A valid access to any segment other than 0, 2, 3 or 4 gives no select and no error.
- R10: At most one select is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Access address |
| bus_valid | input | 1 | Access present this cycle |
| swap_wr | input | 1 | Write strobe for the swap register |
| swap_wdata | input | 2 | New swap code (00 ROM, 01 SDRAM, 10 bank, 11 reserved) |
| sel_rom | output | 1 | Boot ROM selected |
| sel_sdram | output | 1 | SDRAM selected |
| sel_bank | output | 1 | Chip-select-0 memory bank selected |
| out_offset | output | 26 | Offset into the selected region |
| bus_err | output | 1 | One-cycle error strobe for an unmapped segment-0 access |

## Verification
The bench writes a new swap code in the same cycle as a segment-0 access. A decoder that forwards the new code early would route that access to the new target instead of the ROM. After each remap, the bench revisits all three home segments. This catches a decoder that lets the alias leak into home decoding and so moves the ROM or the bank. Back-to-back accesses under the reserved code must give one error pulse each, followed by silence on an idle cycle. A reset in mid-run must restore the ROM alias; a swap register without reset would keep the SDRAM or bank mapping.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        SWAP_ROM   = 2'b00,
        SWAP_SDRAM = 2'b01,
        SWAP_BANK  = 2'b10,
        SWAP_RSVD  = 2'b11
    } swap_e;

    typedef struct packed {
        logic rom;
        logic sdram;
        logic bank;
        logic err;
    } route_t;

endpackage

// File: rtl/lsr_swap_reg.sv
module lsr_swap_reg
    import lsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  swap_e wr_code,
    output swap_e code_q
);

    swap_e code_d;

    always_comb begin
        code_d = code_q;
        if (wr_en) begin
            code_d = wr_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= SWAP_ROM;
        end else begin
            code_q <= code_d;
        end
    end

    // R7: the code only changes on a write
    p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code_q));

    // R7: a write lands on the next edge
    p_code_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> code_q == $past(wr_code));

endmodule

// File: rtl/lsr_seg_decode.sv
module lsr_seg_decode
    import lsr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_W     = 6,
    parameter int SEG_SDRAM = 2,
    parameter int SEG_BANK  = 3,
    parameter int SEG_ROM   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    input  swap_e             code,
    output route_t            route
);

    localparam int OFF_W = ADDR_W - SEG_W;

    logic [SEG_W-1:0] seg;
    logic             alias_hit;
    route_t           home;
    route_t           alias_route;

    assign seg       = addr[ADDR_W-1 -: SEG_W];
    assign alias_hit = (seg == '0);

    // home segments ignore the swap code entirely
    always_comb begin
        home       = '0;
        home.rom   = (seg == SEG_W'(SEG_ROM));
        home.sdram = (seg == SEG_W'(SEG_SDRAM));
        home.bank  = (seg == SEG_W'(SEG_BANK));
    end

    // alias target follows the swap code
    always_comb begin
        alias_route = '0;
        unique case (code)
            SWAP_ROM:   alias_route.rom   = 1'b1;
            SWAP_SDRAM: alias_route.sdram = 1'b1;
            SWAP_BANK:  alias_route.bank  = 1'b1;
            default:    alias_route.err   = 1'b1;
        endcase
    end

    always_comb begin
        route = '0;
        if (valid) begin
            route = alias_hit ? alias_route : home;
        end
    end

    initial begin
        assert (OFF_W > 0 && SEG_ROM != 0 && SEG_SDRAM != 0 && SEG_BANK != 0)
            else $error("segment parameters overlap the alias");
    end

endmodule

// File: rtl/lsr_decoder.sv
module lsr_decoder
    import lsr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SEG_W     = 6,
    parameter int SEG_SDRAM = 2,
    parameter int SEG_BANK  = 3,
    parameter int SEG_ROM   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         bus_addr,
    input  logic                bus_valid,
    input  logic                swap_wr,
    input  logic [1:0]          swap_wdata,
    output logic                sel_rom,
    output logic                sel_sdram,
    output logic                sel_bank,
    output logic [25:0]         out_offset,
    output logic                bus_err
);

    localparam int OFF_W = ADDR_W - SEG_W;

    typedef struct packed {
        route_t           route;
        logic [OFF_W-1:0] off;
    } state_t;

    swap_e  code_q;
    route_t route_c;
    state_t state_d;
    state_t state_q;

    lsr_swap_reg u_swap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (swap_wr),
        .wr_code (swap_e'(swap_wdata)),
        .code_q  (code_q)
    );

    lsr_seg_decode #(
        .ADDR_W    (ADDR_W),
        .SEG_W     (SEG_W),
        .SEG_SDRAM (SEG_SDRAM),
        .SEG_BANK  (SEG_BANK),
        .SEG_ROM   (SEG_ROM)
    ) u_dec (
        .addr  (bus_addr[ADDR_W-1:0]),
        .valid (bus_valid),
        .code  (code_q),
        .route (route_c)
    );

    always_comb begin
        state_d       = '0;
        state_d.route = route_c;
        if (route_c.rom || route_c.sdram || route_c.bank) begin
            state_d.off = bus_addr[OFF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sel_rom    = state_q.route.rom;
    assign sel_sdram  = state_q.route.sdram;
    assign sel_bank   = state_q.route.bank;
    assign bus_err    = state_q.route.err;
    assign out_offset = 26'(state_q.off);

    p_onehot_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rom, sel_sdram, sel_bank}));

    p_err_nosel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !(sel_rom || sel_sdram || sel_bank) && out_offset == '0);

    p_rsvd_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_addr[ADDR_W-1 -: SEG_W] == '0 && code_q == SWAP_RSVD
        |=> bus_err);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !(sel_rom || sel_sdram || sel_bank || bus_err));

    p_home_rom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_addr[ADDR_W-1 -: SEG_W] == SEG_W'(SEG_ROM)
        |=> sel_rom && out_offset == $past(bus_addr[25:0]));

endmodule

// File: tb/lsr_decoder_tb.sv
module lsr_decoder_tb;

    typedef struct {
        logic        rom;
        logic        sdram;
        logic        bank;
        logic        err;
        logic [25:0] off;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_valid = 1'b0;
    logic        swap_wr = 1'b0;
    logic [1:0]  swap_wdata = '0;
    logic        sel_rom, sel_sdram, sel_bank, bus_err;
    logic [25:0] out_offset;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cycles   = 0;
    logic [1:0] model_code = 2'b00;
    exp_t q[$];

    always #2.5 clk = ~clk;

    lsr_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_valid  (bus_valid),
        .swap_wr    (swap_wr),
        .swap_wdata (swap_wdata),
        .sel_rom    (sel_rom),
        .sel_sdram  (sel_sdram),
        .sel_bank   (sel_bank),
        .out_offset (out_offset),
        .bus_err    (bus_err)
    );

    function automatic exp_t model(input logic [31:0] a, input logic v, input string tag);
        exp_t e;
        logic [5:0] seg;
        e = '{rom: 1'b0, sdram: 1'b0, bank: 1'b0, err: 1'b0, off: '0, tag: tag};
        seg = a[31:26];
        if (v) begin
            if (seg == 6'd0) begin
                case (model_code)
                    2'b00: e.rom = 1'b1;
                    2'b01: e.sdram = 1'b1;
                    2'b10: e.bank = 1'b1;
                    default: e.err = 1'b1;
                endcase
            end else if (seg == 6'd4) e.rom = 1'b1;
            else if (seg == 6'd2) e.sdram = 1'b1;
            else if (seg == 6'd3) e.bank = 1'b1;
            if (e.rom || e.sdram || e.bank) e.off = a[25:0];
        end
        return e;
    endfunction

    // driver: one call per cycle, pushes the expected result
    task automatic step(input logic [31:0] a, input logic v,
                        input logic wr, input logic [1:0] wd, input string tag);
        @(negedge clk);
        bus_addr = a; bus_valid = v; swap_wr = wr; swap_wdata = wd;
        q.push_back(model(a, v, tag));
        if (wr) model_code = wd;
    endtask

    task automatic acc(input logic [31:0] a, input string tag);
        step(a, 1'b1, 1'b0, 2'b00, tag);
    endtask

    task automatic idle(input string tag);
        step(32'h0, 1'b0, 1'b0, 2'b00, tag);
    endtask

    // monitor
    always begin
        @(posedge clk);
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks++;
            if (sel_rom !== e.rom || sel_sdram !== e.sdram || sel_bank !== e.bank ||
                bus_err !== e.err || out_offset !== e.off) begin
                n_errors++;
                $display("FAIL %s: got rom=%b sdram=%b bank=%b err=%b off=%h, exp rom=%b sdram=%b bank=%b err=%b off=%h",
                         e.tag, sel_rom, sel_sdram, sel_bank, bus_err, out_offset,
                         e.rom, e.sdram, e.bank, e.err, e.off);
            end
        end
    end

    task automatic check_zero(input string tag);
        n_checks++;
        if (sel_rom || sel_sdram || sel_bank || bus_err || out_offset != '0) begin
            n_errors++;
            $display("FAIL %s: got rom=%b sdram=%b bank=%b err=%b off=%h, exp all 0",
                     tag, sel_rom, sel_sdram, sel_bank, bus_err, out_offset);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_errors++;
            $display("FAIL watchdog: got %0d cycles, exp under 5000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check_zero("R1 in reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check_zero("R1 after release");

        acc(32'h0000_0000, "R2 reset vector");
        acc(32'h0000_001C, "R2 vector 0x1C");
        acc(32'h0000_001F, "R2 vector 0x1F");
        acc(32'h03FF_FFF0, "R2 top of alias");
        acc(32'h1000_0040, "R6 rom home");
        acc(32'h0800_1234, "R6 sdram home");
        acc(32'h0C00_0010, "R6 bank home");
        acc(32'h0400_0000, "R9 segment 1");
        acc(32'hFC00_0008, "R9 segment 63");
        acc(32'h1400_0000, "R9 segment 5");
        idle("R8 idle");

        step(32'h0000_0004, 1'b1, 1'b1, 2'b01, "R7 write same cycle old code");
        acc(32'h0000_0018, "R3 sdram alias");
        acc(32'h1000_0008, "R6 rom home under sdram");
        acc(32'h0800_0100, "R6 sdram home under sdram");
        acc(32'h0C00_0100, "R6 bank home under sdram");

        step(32'h0000_0000, 1'b0, 1'b1, 2'b10, "R8 idle during write");
        acc(32'h0000_0008, "R4 bank alias");
        acc(32'h0123_4567, "R4 bank alias offset");
        acc(32'h1000_0000, "R6 rom home under bank");

        step(32'h0000_000C, 1'b1, 1'b1, 2'b11, "R7 old code bank");
        acc(32'h0000_0000, "R5 reserved first");
        acc(32'h0000_0010, "R5 reserved second");
        idle("R5 pulse ends");
        acc(32'h1000_0020, "R6 rom home under reserved");
        acc(32'h0C00_0020, "R6 bank home under reserved");
        acc(32'h0000_0014, "R5 reserved after home");
        acc(32'h0800_0000, "R10 sdram after error");

        step(32'h0000_0000, 1'b0, 1'b1, 2'b01, "R8 idle write sdram");
        acc(32'h0000_001C, "R3 sdram before reset");
        idle("R8 idle before reset");
        wait (q.size() == 0);
        @(negedge clk) rst_n = 1'b0;
        model_code = 2'b00;
        @(posedge clk); #1 check_zero("R1 mid-run reset");
        @(negedge clk) rst_n = 1'b1;
        acc(32'h0000_0000, "R1 alias back to rom");
        acc(32'h0000_001F, "R2 vector after reset");
        idle("R8 final idle");
        wait (q.size() == 0);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule